// File: doc/BRIEF.md
# Per-Pin Configurable Interrupt Detector

This block watches 32 already-synchronized input pins and turns selected activity on each of them into an interrupt. Every pin carries its own 4-bit sense field. The field picks one of five conditions: rising edge, falling edge, high level, low level, or any edge. A pin whose condition occurs, and whose input gate is open, sets a pending latch. Software clears that latch by writing a one to the acknowledge register. A separate enable vector, changed only through dedicated set and clear registers, masks the pending bits. The masked result drives two request lines, one for pins 0 to 15 and one for pins 16 to 31.

Software reaches the block through a plain single-cycle register port. Writes take effect at the clock edge on which the write strobe is high. Reads return combinationally from the offset on the address bus. Offsets below 0x40 form the control window. Offsets from 0x40 upward form the sense-field window. An offset that matches no register reads as zero.

Top module: `pin_irq_detect`

## Requirements
- R1: The sense field of pin p is held in the register at offset 0x40 + 4*(p/8), at bits [(p mod 8)*4+3 : (p mod 8)*4]. The four sense registers are read-write. Offsets 0x40 and above decode only to the sense window.
- R2: Field code 0 (rising) sets pin p's pending bit on the clock edge at which pin p is 1 and was 0 at the previous edge. A falling transition does not set it.
- R3: Field code 1 (falling) sets the pending bit on a 1-to-0 transition only.
- R4: Field code 2 (high level) sets the pending bit at every edge on which the pin is 1. An acknowledge issued while the pin is still 1 leaves the bit set.
- R5: Field code 3 (low level) sets the pending bit at every edge on which the pin is 0.
- R6: Field code 4 (both edges) sets the pending bit on either transition.
- R7: Field codes 5, 6 and 7 (and 13, 14 and 15) never set a pending bit.
- R8: The input-gate register at 0x14 is read-write and resets to 0. A pin whose gate bit is 0 never sets its pending bit.
- R9: Writing ones to 0x18 sets those enable bits, and writing ones to 0x1C clears them. Both offsets read back the enable vector, which resets to 0.
- R10: Writing ones to 0x28 clears exactly those pending bits. The other pending bits are unaffected, and 0x28 reads as 0.
- R11: Offset 0x20 returns the raw pending vector, and 0x24 returns the pending vector ANDed with the enable vector. Both are 0 after reset.
- R12: irq_lo is the OR of masked bits 15:0, and irq_hi is the OR of masked bits 31:16.
- R13: Bit 3 of a sense field is a mode flag with no effect on detection, so codes 8 to 12 behave like codes 0 to 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pin_in | input | 32 | Synchronized pin levels |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 8 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| irq_lo | output | 1 | Request for pins 0 to 15 |
| irq_hi | output | 1 | Request for pins 16 to 31 |

## Verification
The hardest case to reach is an acknowledge that lands while a level condition still holds. The clear and the fresh set meet on the same edge, and the bit must remain set. The bench holds a pin high under the high-level code, writes its acknowledge bit, and reads the raw vector on the next half cycle. It then drops the pin and acknowledges again to show that the clear now sticks. A second hard case is a pin whose request must stay silent while its neighbours fire. Several pins are made pending and enabled one at a time, and the bench watches the two request lines as single bits are acknowledged and disabled.

// File: rtl/pid_pkg.sv
package pid_pkg;

  typedef enum logic [2:0] {
    SNS_RISE = 3'd0,
    SNS_FALL = 3'd1,
    SNS_HIGH = 3'd2,
    SNS_LOW  = 3'd3,
    SNS_BOTH = 3'd4
  } sense_e;

  localparam int ADR_GATE   = 'h14;
  localparam int ADR_EN_SET = 'h18;
  localparam int ADR_EN_CLR = 'h1C;
  localparam int ADR_RAW    = 'h20;
  localparam int ADR_MASKED = 'h24;
  localparam int ADR_ACK    = 'h28;
  localparam int ADR_SENSE0 = 'h40;

  // Detection rule: low three bits select the condition, bit 3 is ignored.
  function automatic logic sense_hit(logic [3:0] fld, logic cur, logic prv);
    logic res;
    case (fld[2:0])
      SNS_RISE: res = cur & ~prv;
      SNS_FALL: res = ~cur & prv;
      SNS_HIGH: res = cur;
      SNS_LOW:  res = ~cur;
      SNS_BOTH: res = cur ^ prv;
      default:  res = 1'b0;
    endcase
    return res;
  endfunction

  function automatic logic any_bit(logic [15:0] v);
    return |v;
  endfunction

endpackage

// File: rtl/pid_regs.sv
module pid_regs
  import pid_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int FIELD_W = 4,
  parameter int ADDR_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [NPINS-1:0]         wdata,
  input  logic [NPINS-1:0]         raw_in,
  input  logic [NPINS-1:0]         masked_in,
  output logic [NPINS-1:0]         rdata,
  output logic [NPINS-1:0]         gate_q,
  output logic [NPINS-1:0]         en_q,
  output logic [NPINS-1:0]         ack_mask,
  output logic [NPINS*FIELD_W-1:0] sense_flat
);
  localparam int PER_REG = NPINS / FIELD_W;
  localparam int NSENSE  = NPINS / PER_REG;

  logic                 win_hi;
  logic                 hit_gate, hit_set, hit_clr, hit_ack;
  logic [NPINS-1:0]     set_mask, clr_mask;
  logic [NPINS-1:0]     sense_q [NSENSE];

  assign win_hi   = addr >= ADDR_W'(ADR_SENSE0);
  assign hit_gate = !win_hi && addr == ADDR_W'(ADR_GATE);
  assign hit_set  = !win_hi && addr == ADDR_W'(ADR_EN_SET);
  assign hit_clr  = !win_hi && addr == ADDR_W'(ADR_EN_CLR);
  assign hit_ack  = !win_hi && addr == ADDR_W'(ADR_ACK);

  assign set_mask = (wr_en && hit_set) ? wdata : '0;
  assign clr_mask = (wr_en && hit_clr) ? wdata : '0;
  assign ack_mask = (wr_en && hit_ack) ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_q <= '0;
      en_q   <= '0;
    end else begin
      if (wr_en && hit_gate) gate_q <= wdata;
      en_q <= (en_q | set_mask) & ~clr_mask;
    end
  end

  for (genvar i = 0; i < NSENSE; i++) begin : g_sense
    logic sel;
    assign sel = win_hi && addr == ADDR_W'(ADR_SENSE0 + 4 * i);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sense_q[i] <= '0;
      else if (wr_en && sel) sense_q[i] <= wdata;
    end
    assign sense_flat[i*NPINS +: NPINS] = sense_q[i];
  end

  always_comb begin
    rdata = '0;
    if (win_hi) begin
      for (int i = 0; i < NSENSE; i++)
        if (addr == ADDR_W'(ADR_SENSE0 + 4 * i)) rdata = sense_q[i];
    end else begin
      if (hit_gate)                    rdata = gate_q;
      if (hit_set || hit_clr)          rdata = en_q;
      if (addr == ADDR_W'(ADR_RAW))    rdata = raw_in;
      if (addr == ADDR_W'(ADR_MASKED)) rdata = masked_in;
    end
  end

  // R9: bits written to the set register are enabled on the next cycle
  assert_enable_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_set) |=> ((en_q & $past(wdata)) == $past(wdata)));

  // R9: bits written to the clear register are disabled on the next cycle
  assert_enable_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit_clr) |=> ((en_q & $past(wdata)) == '0));

endmodule

// File: rtl/pid_detect.sv
module pid_detect
  import pid_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int FIELD_W = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NPINS-1:0]         pins,
  input  logic [NPINS*FIELD_W-1:0] sense_flat,
  output logic [NPINS-1:0]         hit
);
  logic [NPINS-1:0] prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= pins;
  end

  for (genvar g = 0; g < NPINS; g++) begin : g_pin
    logic [FIELD_W-1:0] fld;
    assign fld    = sense_flat[g*FIELD_W +: FIELD_W];
    assign hit[g] = sense_hit(fld[3:0], pins[g], prev_q[g]);

    // R7: reserved codes produce no detection event
    assert_reserved_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (fld[2:0] > 3'd4) |-> !hit[g]);
  end

endmodule

// File: rtl/pid_pending.sv
module pid_pending
  import pid_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] hit,
  input  logic [NPINS-1:0] gate,
  input  logic [NPINS-1:0] enable,
  input  logic [NPINS-1:0] ack,
  output logic [NPINS-1:0] pend_q,
  output logic [NPINS-1:0] masked,
  output logic             irq_lo,
  output logic             irq_hi
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0] set_ev;

  assign set_ev = hit & gate;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~ack) | set_ev;
  end

  assign masked = pend_q & enable;
  assign irq_lo = any_bit(masked[HALF-1:0]);
  assign irq_hi = any_bit(masked[NPINS-1:HALF]);

  // R8: a pending bit never rises while its gate was closed
  assert_gate_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(gate)) == '0));

  // R10: acknowledged bits with no fresh event are clear next cycle
  assert_ack_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (ack != '0) |=> ((pend_q & $past(ack & ~set_ev)) == '0));

endmodule

// File: rtl/pin_irq_detect.sv
module pin_irq_detect
  import pid_pkg::*;
#(
  parameter int NPINS   = 32,
  parameter int FIELD_W = 4,
  parameter int ADDR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPINS-1:0]  pin_in,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  output logic              irq_lo,
  output logic              irq_hi
);
  localparam int HALF = NPINS / 2;

  logic [NPINS-1:0]         gate_w, en_w, ack_w, hit_w, pend_w, masked_w;
  logic [NPINS*FIELD_W-1:0] sense_w;

  pid_regs #(.NPINS(NPINS), .FIELD_W(FIELD_W), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .raw_in(pend_w), .masked_in(masked_w),
    .rdata(bus_rdata), .gate_q(gate_w), .en_q(en_w), .ack_mask(ack_w),
    .sense_flat(sense_w)
  );

  pid_detect #(.NPINS(NPINS), .FIELD_W(FIELD_W)) u_detect (
    .clk(clk), .rst_n(rst_n), .pins(pin_in), .sense_flat(sense_w), .hit(hit_w)
  );

  pid_pending #(.NPINS(NPINS)) u_pending (
    .clk(clk), .rst_n(rst_n), .hit(hit_w), .gate(gate_w), .enable(en_w),
    .ack(ack_w), .pend_q(pend_w), .masked(masked_w),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  // R12: each request line implies an enabled pending pin in its half
  assert_irq_lo_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lo |-> ((pend_w[HALF-1:0] & en_w[HALF-1:0]) != '0));
  assert_irq_hi_src_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_hi |-> ((pend_w[NPINS-1:HALF] & en_w[NPINS-1:HALF]) != '0));

endmodule

// File: tb/tb_pin_irq_detect.sv
module tb_pin_irq_detect;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin_in = '0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_lo, irq_hi;
  int          n_cmp = 0, n_bad = 0;
  bit          done = 0;

  always #2.5 clk = ~clk;

  pin_irq_detect dut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_lo(irq_lo), .irq_hi(irq_hi)
  );

  task automatic check(string tag, logic [31:0] got, logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic pin(int idx, logic v);
    @(negedge clk);
    pin_in[idx] = v;
    @(negedge clk);
  endtask

  task automatic expect_raw(string tag, logic [31:0] exp);
    logic [31:0] d;
    rd(8'h20, d);
    check(tag, d, exp);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(8'h14, d); check("R8 gate reset", d, 0);
    rd(8'h18, d); check("R9 enable reset", d, 0);
    rd(8'h20, d); check("R11 raw reset", d, 0);
    rd(8'h24, d); check("R11 masked reset", d, 0);
    rd(8'h40, d); check("R1 sense reset", d, 0);
    check("R12 irq reset", {30'd0, irq_hi, irq_lo}, 0);
  endtask

  task automatic t_layout;
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, d); check("R8 gate readback", d, 32'hFFFF_FFFF);
    wr(8'h44, 32'h0000_A000);
    rd(8'h44, d); check("R1 sense readback", d, 32'h0000_A000);
    pin(11, 1'b1);
    expect_raw("R1 pin11 field in 0x44[15:12]", 32'h0000_0800);
    pin(11, 1'b0);
    wr(8'h28, 32'h0000_0800);
    expect_raw("R1 pin11 cleared", 0);
  endtask

  task automatic t_rise;
    wr(8'h40, 32'h0000_8000);
    pin(3, 1'b1);
    expect_raw("R2 rising sets", 32'h8);
    wr(8'h28, 32'h8);
    pin(3, 1'b0);
    expect_raw("R2 falling ignored", 0);
    pin(5, 1'b1);
    expect_raw("R13 code 0 equals code 8", 32'h20);
    pin(5, 1'b0);
    wr(8'h28, 32'h20);
  endtask

  task automatic t_fall;
    wr(8'h48, 32'h0009_0000);
    pin(20, 1'b1);
    expect_raw("R3 rise ignored", 0);
    pin(20, 1'b0);
    expect_raw("R3 fall sets", 32'h0010_0000);
    wr(8'h28, 32'h0010_0000);
    expect_raw("R10 ack clears", 0);
  endtask

  task automatic t_high;
    wr(8'h44, 32'h000A_A000);
    pin(12, 1'b1);
    expect_raw("R4 high sets", 32'h1000);
    wr(8'h28, 32'h1000);
    expect_raw("R4 ack while high keeps", 32'h1000);
    pin(12, 1'b0);
    wr(8'h28, 32'h1000);
    expect_raw("R4 ack after low clears", 0);
  endtask

  task automatic t_low;
    wr(8'h4C, 32'h0B00_0000);
    @(negedge clk);
    expect_raw("R5 low level sets", 32'h4000_0000);
    pin(30, 1'b1);
    wr(8'h28, 32'h4000_0000);
    expect_raw("R5 high clears", 0);
    wr(8'h4C, 32'h0);
    pin(30, 1'b0);
    expect_raw("R5 restore quiet", 0);
  endtask

  task automatic t_both;
    wr(8'h40, 32'hC000_8000);
    pin(7, 1'b1);
    expect_raw("R6 both rise", 32'h80);
    wr(8'h28, 32'h80);
    pin(7, 1'b0);
    expect_raw("R6 both fall", 32'h80);
    wr(8'h28, 32'h80);
  endtask

  task automatic t_reserved;
    wr(8'h40, 32'hC000_85D0);
    pin(1, 1'b1); pin(2, 1'b1);
    expect_raw("R7 reserved high", 0);
    pin(1, 1'b0); pin(2, 1'b0);
    @(negedge clk);
    expect_raw("R7 reserved low", 0);
  endtask

  task automatic t_gate;
    logic [31:0] d;
    wr(8'h14, 32'hFFFF_FDFF);
    rd(8'h14, d); check("R8 gate write", d, 32'hFFFF_FDFF);
    pin(9, 1'b1);
    expect_raw("R8 gated pin blocked", 0);
    wr(8'h14, 32'hFFFF_FFFF);
    pin(9, 1'b0);
  endtask

  task automatic t_enable;
    logic [31:0] d;
    @(negedge clk);
    pin_in[5] = 1'b1; pin_in[17] = 1'b1;
    @(negedge clk);
    expect_raw("R11 raw two pins", 32'h0002_0020);
    rd(8'h24, d); check("R11 masked none", d, 0);
    check("R12 irqs idle", {30'd0, irq_hi, irq_lo}, 0);
    wr(8'h18, 32'h20);
    rd(8'h18, d); check("R9 enable set", d, 32'h20);
    rd(8'h24, d); check("R11 masked one", d, 32'h20);
    check("R12 lo only", {30'd0, irq_hi, irq_lo}, 32'h1);
    wr(8'h18, 32'h0002_0000);
    check("R12 both", {30'd0, irq_hi, irq_lo}, 32'h3);
    wr(8'h1C, 32'h20);
    rd(8'h1C, d); check("R9 enable clear", d, 32'h0002_0000);
    check("R12 hi only", {30'd0, irq_hi, irq_lo}, 32'h2);
    wr(8'h28, 32'h0002_0000);
    expect_raw("R10 only acked bit cleared", 32'h20);
    rd(8'h28, d); check("R10 ack reads zero", d, 0);
    check("R12 hi drops", {30'd0, irq_hi, irq_lo}, 0);
    wr(8'h28, 32'h20);
    expect_raw("R10 final clear", 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_layout;
    t_rise;
    t_fall;
    t_high;
    t_low;
    t_both;
    t_reserved;
    t_gate;
    t_enable;
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule